// File: doc/BRIEF.md
# Dual Store Queue Write Buffer

This block sits beside a processor core's store path and gives it two write-combining buffers, each 32 bytes deep as eight longword slots. Stores that fall inside a dedicated address window are steered into one of the two buffers by address decode. Longword and quadword store sizes are supported. A later flush command sends the whole contents of one buffer to external memory as an 8-beat burst.

Each buffer has a small control register of its own. It supplies the upper external address bits of that buffer's burst, and the rest of the burst address comes from the flush command. A module-stop input halts all queue activity and shuts off access to both control registers. While a buffer is draining, stores aimed at that buffer are held off with a ready signal, and the other buffer keeps taking stores.

Top module: `sq_write_buffer`

## Requirements
- R1: A store is taken into a queue only when st_addr_i[31:26] equals 6'b111000. Any other store is ignored: it leaves every queue entry unchanged and is never stalled.
- R2: st_addr_i[5] picks the queue (0 for queue 0, 1 for queue 1), and st_addr_i[4:2] picks the longword entry 0..7 within it.
- R3: st_size_i 2'b10 is a longword store, which writes st_data_i[31:0] into the selected entry. The codes 2'b00 and 2'b01 are unsupported and are ignored with no change to the queues.
- R4: st_size_i 2'b11 is a quadword store. It writes st_data_i[31:0] to entry n and st_data_i[63:32] to entry n+1, where n = st_addr_i[4:2] and st_addr_i[2] must be 0. If st_addr_i[2] is 1, the store is dropped and st_err_o is high for exactly the one cycle after the handshake.
- R5: Each queue has a 3-bit control register, reset to 0. It is written with cfg_wdata_i when cfg_we_i is high, and cfg_sel_i picks the register. cfg_rdata_o shows the register picked by cfg_sel_i in the same cycle.
- R6: While stop_i is high, st_ready_o and flush_ready_o are 0, cfg_rdata_o reads 0, and control register writes have no effect.
- R7: A flush accepted with flush_addr_i[31:26] = 6'b111000 produces one 8-beat burst from the queue picked by flush_addr_i[5]. Beat k carries entry k, and bw_last_o is high only on beat 7. A flush outside the window is ignored.
- R8: During the whole burst, bw_addr_o equals {3'b000, control register of the flushed queue, flush_addr_i[25:6], 6'b000000}, using the values captured when the flush was accepted.
- R9: While a burst is outstanding, a store to the draining queue sees st_ready_o = 0, a store to the other queue sees st_ready_o = 1 and is written, and an in-window flush sees flush_ready_o = 0.
- R10: While bw_valid_o is high and bw_ready_i is low, the next cycle keeps bw_valid_o high with bw_data_o, bw_addr_o and bw_last_o unchanged.
- R11: After reset, all queue entries and both control registers are zero and no burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Module stop: halts the queues and blocks register access |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted in this cycle |
| st_addr_i | input | 32 | Store byte address |
| st_data_i | input | 64 | Store data, low longword in [31:0] |
| st_size_i | input | 2 | Store size code |
| st_err_o | output | 1 | Pulse for a dropped misaligned quadword |
| flush_valid_i | input | 1 | Flush request |
| flush_ready_o | output | 1 | Flush accepted in this cycle |
| flush_addr_i | input | 32 | Flush address: window tag, queue select and target bits |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 1 | Control register select |
| cfg_wdata_i | input | 3 | Control register write data |
| cfg_rdata_o | output | 3 | Control register read data |
| bw_valid_o | output | 1 | Burst beat valid |
| bw_ready_i | input | 1 | Burst beat taken |
| bw_addr_o | output | 32 | Burst start address |
| bw_data_o | output | 32 | Burst beat data |
| bw_last_o | output | 1 | Final beat of the burst |

## Verification
The assertions check on every cycle the behaviour that needs no memory of earlier data. This covers the refusals under stop, the burst beat holding steady under backpressure, the burst address alignment, bw_last_o falling on the eighth handshake, and st_err_o appearing only after a misaligned quadword. Whether the right longword lands in the right entry, and whether ignored stores really leave the contents alone, can only be seen from the bench's scenarios. Those scenarios sweep every entry of both queues with every size code and alignment, then drain the queues and compare each beat with a model.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned NQ       = 2;
  localparam int unsigned NENT     = 8;
  localparam int unsigned LW       = 32;
  localparam int unsigned IDXW     = $clog2(NENT);
  localparam int unsigned CRW      = 3;
  localparam logic [5:0]  WIN_TAG  = 6'b111000;

  typedef enum logic [1:0] {
    SZ_RSV0 = 2'b00,
    SZ_RSV1 = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } st_size_e;
endpackage

// File: rtl/sq_decode.sv
module sq_decode
  import sq_pkg::*;
(
  input  logic [5:0]      tag_i,
  input  logic [5:2]      lo_i,
  input  logic [1:0]      size_i,
  output logic            in_win_o,
  output logic            q_o,
  output logic [IDXW-1:0] idx_o,
  output logic            is_long_o,
  output logic            is_quad_o,
  output logic            misal_o
);
  always_comb begin
    in_win_o  = (tag_i == WIN_TAG);
    q_o       = lo_i[5];
    idx_o     = lo_i[4:2];
    is_long_o = (size_i == SZ_LONG);
    is_quad_o = (size_i == SZ_QUAD);
    misal_o   = is_quad_o && lo_i[2];
  end
endmodule

// File: rtl/sq_store_bank.sv
module sq_store_bank
  import sq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_lo_i,
  input  logic            we_hi_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [LW-1:0]   lo_i,
  input  logic [LW-1:0]   hi_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [LW-1:0]   rd_o
);
  logic [NENT-1:0][LW-1:0] mem_q;
  logic [IDXW-1:0]         idx_hi;

  assign idx_hi = idx_i + IDXW'(1);
  assign rd_o   = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      if (we_lo_i) mem_q[idx_i]  <= lo_i;
      if (we_hi_i) mem_q[idx_hi] <= hi_i;
    end
  end
endmodule

// File: rtl/sq_ctrl_regs.sv
module sq_ctrl_regs
  import sq_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stop_i,
  input  logic                   we_i,
  input  logic                   sel_i,
  input  logic [CRW-1:0]         wdata_i,
  output logic [CRW-1:0]         rdata_o,
  output logic [NQ-1:0][CRW-1:0] reg_o
);
  logic [NQ-1:0][CRW-1:0] reg_q;

  for (genvar g = 0; g < NQ; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                reg_q[g] <= '0;
      else if (we_i && !stop_i && sel_i == g[0])  reg_q[g] <= wdata_i;
    end
  end

  assign rdata_o = stop_i ? '0 : reg_q[sel_i];
  assign reg_o   = reg_q;
endmodule

// File: rtl/sq_drain.sv
module sq_drain
  import sq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            start_q_i,
  input  logic [31:0]     start_addr_i,
  input  logic            bw_ready_i,
  output logic [NQ-1:0]   busy_o,
  output logic            q_o,
  output logic [IDXW-1:0] beat_o,
  output logic            bw_valid_o,
  output logic            bw_last_o,
  output logic [31:0]     bw_addr_o
);
  logic            act_q;
  logic            q_q;
  logic [IDXW-1:0] beat_q;
  logic [31:0]     addr_q;
  logic            last;

  assign last = (beat_q == IDXW'(NENT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      q_q    <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
    end else if (!act_q) begin
      if (start_i) begin
        act_q  <= 1'b1;
        q_q    <= start_q_i;
        beat_q <= '0;
        addr_q <= start_addr_i;
      end
    end else if (bw_ready_i) begin
      beat_q <= beat_q + IDXW'(1);
      if (last) act_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_busy
    assign busy_o[g] = act_q && (q_q == g[0]);
  end

  assign q_o        = q_q;
  assign beat_o     = beat_q;
  assign bw_valid_o = act_q;
  assign bw_last_o  = act_q && last;
  assign bw_addr_o  = addr_q;
endmodule

// File: rtl/sq_write_buffer.sv
module sq_write_buffer
  import sq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stop_i,
  input  logic        st_valid_i,
  output logic        st_ready_o,
  input  logic [31:0] st_addr_i,
  input  logic [63:0] st_data_i,
  input  logic [1:0]  st_size_i,
  output logic        st_err_o,
  input  logic        flush_valid_i,
  output logic        flush_ready_o,
  input  logic [31:0] flush_addr_i,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [2:0]  cfg_wdata_i,
  output logic [2:0]  cfg_rdata_o,
  output logic        bw_valid_o,
  input  logic        bw_ready_i,
  output logic [31:0] bw_addr_o,
  output logic [31:0] bw_data_o,
  output logic        bw_last_o
);
  logic            s_win, s_q, s_long, s_quad, s_mis;
  logic [IDXW-1:0] s_idx;
  logic            f_win, f_q;
  logic [IDXW-1:0] f_idx_unused;
  logic            f_long_unused, f_quad_unused, f_mis_unused;
  logic [NQ-1:0]   busy;
  logic            d_q;
  logic [IDXW-1:0] d_beat;
  logic [NQ-1:0][CRW-1:0] creg;
  logic [NQ-1:0][LW-1:0]  rd;
  logic            st_fire, fl_fire, err_q;
  logic            unused_bits;

  assign unused_bits = ^{st_addr_i[25:6], st_addr_i[1:0], flush_addr_i[4:0]};

  sq_decode u_dec_st (
    .tag_i(st_addr_i[31:26]), .lo_i(st_addr_i[5:2]), .size_i(st_size_i),
    .in_win_o(s_win), .q_o(s_q), .idx_o(s_idx),
    .is_long_o(s_long), .is_quad_o(s_quad), .misal_o(s_mis)
  );

  sq_decode u_dec_fl (
    .tag_i(flush_addr_i[31:26]), .lo_i(flush_addr_i[5:2]), .size_i(2'b00),
    .in_win_o(f_win), .q_o(f_q), .idx_o(f_idx_unused),
    .is_long_o(f_long_unused), .is_quad_o(f_quad_unused), .misal_o(f_mis_unused)
  );

  // stall only stores that target the draining queue
  assign st_ready_o    = !stop_i && !(s_win && busy[s_q]);
  assign flush_ready_o = !stop_i && !(f_win && |busy);
  assign st_fire       = st_valid_i && st_ready_o && s_win;
  assign fl_fire       = flush_valid_i && flush_ready_o && f_win;

  for (genvar g = 0; g < NQ; g++) begin : g_bank
    logic hit;
    assign hit = st_fire && (s_q == g[0]);
    sq_store_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_lo_i  (hit && (s_long || (s_quad && !s_mis))),
      .we_hi_i  (hit && s_quad && !s_mis),
      .idx_i    (s_idx),
      .lo_i     (st_data_i[31:0]),
      .hi_i     (st_data_i[63:32]),
      .rd_idx_i (d_beat),
      .rd_o     (rd[g])
    );
  end

  sq_ctrl_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i),
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .reg_o(creg)
  );

  sq_drain u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fl_fire),
    .start_q_i    (f_q),
    .start_addr_i ({3'b000, creg[f_q], flush_addr_i[25:6], 6'b000000}),
    .bw_ready_i   (bw_ready_i),
    .busy_o       (busy),
    .q_o          (d_q),
    .beat_o       (d_beat),
    .bw_valid_o   (bw_valid_o),
    .bw_last_o    (bw_last_o),
    .bw_addr_o    (bw_addr_o)
  );

  assign bw_data_o = rd[d_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= st_fire && s_mis;
  end
  assign st_err_o = err_q;
endmodule

// File: rtl/sq_write_buffer_chk.sv
module sq_write_buffer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stop_i,
  input logic        st_valid_i,
  input logic        st_ready_o,
  input logic [31:0] st_addr_i,
  input logic [1:0]  st_size_i,
  input logic        st_err_o,
  input logic        flush_ready_o,
  input logic [2:0]  cfg_rdata_o,
  input logic        bw_valid_o,
  input logic        bw_ready_i,
  input logic [31:0] bw_addr_o,
  input logic [31:0] bw_data_o,
  input logic        bw_last_o
);
  logic [3:0] hs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hs_cnt <= '0;
    else if (bw_valid_o && bw_ready_i) hs_cnt <= bw_last_o ? 4'd0 : hs_cnt + 4'd1;
  end

  // R6
  stop_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (!st_ready_o && !flush_ready_o && cfg_rdata_o == 3'd0));

  // R10
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_valid_o && !bw_ready_i) |=>
      (bw_valid_o && $stable(bw_data_o) && $stable(bw_addr_o) && $stable(bw_last_o)));

  // R8
  burst_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_valid_o |-> (bw_addr_o[5:0] == 6'd0 && bw_addr_o[31:29] == 3'd0));

  // R7
  last_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_valid_o |-> (bw_last_o == (hs_cnt == 4'd7)));

  // R7
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_last_o |-> bw_valid_o);

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_ready_o && st_addr_i[31:26] == 6'b111000 &&
     st_size_i == 2'b11 && st_addr_i[2]) |=> st_err_o);

  // R4
  err_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_err_o) |-> $past(st_valid_i && st_size_i == 2'b11 && st_addr_i[2]));
endmodule

bind sq_write_buffer sq_write_buffer_chk u_chk (.*);

// File: tb/sim_sq_write_buffer.sv
module sim_sq_write_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, stop_i = 1'b0;
  logic        st_valid_i = 1'b0, st_ready_o, st_err_o;
  logic [31:0] st_addr_i = '0;
  logic [63:0] st_data_i = '0;
  logic [1:0]  st_size_i = '0;
  logic        flush_valid_i = 1'b0, flush_ready_o;
  logic [31:0] flush_addr_i = '0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [2:0]  cfg_wdata_i = '0, cfg_rdata_o;
  logic        bw_valid_o, bw_ready_i = 1'b1, bw_last_o;
  logic [31:0] bw_addr_o, bw_data_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q [2][8];
  logic [2:0]  exp_cr [2];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sq_write_buffer u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] waddr(input int q, input int idx);
    return 32'hE000_0000 | 32'(q << 5) | 32'(idx << 2);
  endfunction

  function automatic void model(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz);
    int q, i;
    if (a[31:26] != 6'b111000) return;
    q = int'(a[5]); i = int'(a[4:2]);
    if (sz == 2'b10) exp_q[q][i] = d[31:0];
    else if (sz == 2'b11 && !a[2]) begin
      exp_q[q][i] = d[31:0]; exp_q[q][i+1] = d[63:32];
    end
  endfunction

  task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz, input string req);
    logic mis;
    mis = (a[31:26] == 6'b111000) && sz == 2'b11 && a[2];
    @(negedge clk_i);
    st_addr_i = a; st_data_i = d; st_size_i = sz; st_valid_i = 1'b1;
    #1 chk(st_ready_o === 1'b1, req, {63'd0, st_ready_o}, 64'd1);
    @(posedge clk_i);
    #1 st_valid_i = 1'b0;
    model(a, d, sz);
    chk(st_err_o === mis, "R4 err", {63'd0, st_err_o}, {63'd0, mis});
  endtask

  task automatic cfg_write(input int sel, input logic [2:0] v);
    @(negedge clk_i);
    cfg_sel_i = sel[0]; cfg_wdata_i = v; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (!stop_i) exp_cr[sel] = v;
  endtask

  task automatic cfg_read(input int sel, input string req);
    logic [2:0] e;
    e = stop_i ? 3'd0 : exp_cr[sel];
    @(negedge clk_i);
    cfg_sel_i = sel[0];
    #1 chk(cfg_rdata_o === e, req, {61'd0, cfg_rdata_o}, {61'd0, e});
  endtask

  // starts a flush; burst is collected by collect()
  task automatic flush_start(input int q, input logic [19:0] tgt);
    @(negedge clk_i);
    flush_addr_i = {6'b111000, tgt, q[0], 5'd0}; flush_valid_i = 1'b1;
    #1 chk(flush_ready_o === 1'b1, "R7 flush ready", {63'd0, flush_ready_o}, 64'd1);
    @(posedge clk_i);
    #1 flush_valid_i = 1'b0;
  endtask

  task automatic collect(input int q, input logic [19:0] tgt);
    logic [31:0] ea;
    ea = {3'b000, exp_cr[q], tgt, 6'd0};
    bw_ready_i = 1'b1;
    @(negedge clk_i);
    for (int b = 0; b < 8; b++) begin
      chk(bw_valid_o === 1'b1, "R7 beat valid", {63'd0, bw_valid_o}, 64'd1);
      chk(bw_data_o === exp_q[q][b], "R7 beat data", {32'd0, bw_data_o}, {32'd0, exp_q[q][b]});
      chk(bw_last_o === (b == 7), "R7 last", {63'd0, bw_last_o}, {63'd0, (b == 7)});
      chk(bw_addr_o === ea, "R8 burst addr", {32'd0, bw_addr_o}, {32'd0, ea});
      @(negedge clk_i);
    end
    chk(bw_valid_o === 1'b0, "R7 burst end", {63'd0, bw_valid_o}, 64'd0);
  endtask

  task automatic flush(input int q, input logic [19:0] tgt);
    flush_start(q, tgt);
    collect(q, tgt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int q = 0; q < 2; q++) begin
      exp_cr[q] = '0;
      for (int i = 0; i < 8; i++) exp_q[q][i] = '0;
    end
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;

    // R11 reset state
    @(negedge clk_i);
    chk(bw_valid_o === 1'b0, "R11 no burst", {63'd0, bw_valid_o}, 64'd0);
    cfg_read(0, "R11 creg0");
    cfg_read(1, "R11 creg1");
    flush(0, 20'h0);
    flush(1, 20'h0);

    // R5 register sweep
    for (int v = 0; v < 8; v++)
      for (int s = 0; s < 2; s++) begin
        cfg_write(s, 3'(v + s * 3));
        cfg_read(s, "R5 readback");
        cfg_read(1 - s, "R5 other reg");
      end
    cfg_write(0, 3'd5);
    cfg_write(1, 3'd2);

    // R2 R3 longword sweep of every entry
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < 8; i++)
        store(waddr(q, i), {32'hDEAD_BEEF, 32'hA000_0000 ^ 32'(q << 16) ^ (32'(i) * 32'h0101_0101)},
              2'b10, "R2 long store");
    flush(0, 20'h12345);
    flush(1, 20'hABCDE);

    // R4 quadword, aligned and misaligned
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < 8; i++)
        store(waddr(q, i), {32'h5500_0000 + 32'(q * 16 + i), 32'h3300_0000 + 32'(q * 16 + i)},
              2'b11, "R4 quad store");
    flush(0, 20'h00001);
    flush(1, 20'hFFFFF);

    // R3 unsupported sizes, R1 out of window
    for (int i = 0; i < 8; i++) begin
      store(waddr(i % 2, i), 64'h1111_2222_3333_4444, 2'(i % 2), "R3 bad size");
      store(waddr(i % 2, i) + 32'h0400_0000, 64'h9999_8888_7777_6666, 2'b10, "R1 above window");
      store(32'h6000_0000 | 32'(i << 2), 64'h9999_8888_7777_6666, 2'b11, "R1 outside window");
    end
    flush(0, 20'h0F0F0);
    flush(1, 20'h0F0F1);

    // R6 stop refuses everything
    @(negedge clk_i);
    stop_i = 1'b1;
    st_addr_i = waddr(0, 0); st_size_i = 2'b10;
    flush_addr_i = waddr(1, 0);
    #1;
    chk(st_ready_o === 1'b0, "R6 store refused", {63'd0, st_ready_o}, 64'd0);
    chk(flush_ready_o === 1'b0, "R6 flush refused", {63'd0, flush_ready_o}, 64'd0);
    cfg_write(0, 3'd7);
    cfg_write(1, 3'd7);
    cfg_read(0, "R6 read zero");
    cfg_read(1, "R6 read zero");
    @(negedge clk_i);
    stop_i = 1'b0;
    cfg_read(0, "R6 write ignored");
    cfg_read(1, "R6 write ignored");

    // R9 R10 stall during burst with backpressure
    for (int i = 0; i < 8; i++) store(waddr(0, i), {32'd0, 32'hC0DE_0000 + 32'(i)}, 2'b10, "R9 preload");
    bw_ready_i = 1'b0;
    flush_start(0, 20'h33333);
    @(negedge clk_i);
    st_addr_i = waddr(0, 3); st_size_i = 2'b10;
    flush_addr_i = waddr(1, 0);
    #1;
    chk(st_ready_o === 1'b0, "R9 same queue stall", {63'd0, st_ready_o}, 64'd0);
    chk(flush_ready_o === 1'b0, "R9 flush held off", {63'd0, flush_ready_o}, 64'd0);
    chk(bw_data_o === exp_q[0][0], "R10 beat held", {32'd0, bw_data_o}, {32'd0, exp_q[0][0]});
    for (int i = 0; i < 8; i++) store(waddr(1, i), {32'd0, 32'hB0B0_0000 + 32'(i)}, 2'b10, "R9 other queue");
    chk(bw_data_o === exp_q[0][0], "R10 beat held", {32'd0, bw_data_o}, {32'd0, exp_q[0][0]});
    collect(0, 20'h33333);
    flush(1, 20'h44444);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule